// File: doc/BRIEF.md
# Shared store/busy line handshake controller

This block sits beside a nonvolatile SRAM and manages one wire that several such memories share with open-drain drivers, so that a whole bank can save its contents together. The block pulls the wire low whenever its own store engine is busy, whatever started that store. It also watches the wire for a low driven by another party. A low that survives a synchronizer, a glitch filter and a minimum-duration qualifier becomes a store request. That request is subject to a supply-good flag and to whether any write has happened since the last save.

After a request qualifies, the memory keeps serving reads for a grace window of a parameterised number of cycles while writes are already refused. An address or control transition inside the window, or a write attempt, cuts the window short and starts the save step at once. The save step either hands a request to the store engine or, when nothing was written, is skipped. In both cases the memory then stays disabled in standby until the shared wire is seen high again, plus a short recovery count. All delays are counted in clock cycles.

Top module: `busy_line_ctrl`

## Requirements
- R1: While and directly after reset, line_pull, store_req, wr_block and standby are all 0.
- R2: The line level passes a SYNC_STAGES synchronizer and then a filter that follows it only after FILT_LEN consecutive equal samples; a raw low of 2 cycles has no effect on any output.
- R3: A filtered low qualifies as an external request only after ASSERT_CYC consecutive low cycles; a raw low of 3 cycles is ignored, and a held low leaves wr_block at 0 for at least the first 6 cycles.
- R4: A qualified request opens a grace window of DELAY_CYC cycles with standby 0 and wr_block 1; with no activity, store_req rises exactly DELAY_CYC cycles after the window opens (5 cycles after the 12th cycle of the low with default parameters).
- R5: An acc_evt pulse during the grace window ends it at the next clock edge, and store_req is 1 in the following cycle.
- R6: A wr_attempt during the grace window sees wr_block at 1 and ends the window at the next clock edge.
- R7: The save step raises store_req only if write_seen is 1 when the window ends; otherwise no store_req is raised and standby goes to 1.
- R8: store_req stays 1 until store_active is seen; line_pull is 1 while store_req or store_active is 1.
- R9: After a store or a skipped store, standby stays 1 while the filtered line is low; once it is high, standby clears after RECOVER_CYC more cycles (at the 9th clock edge after the raw line is released, with defaults).
- R10: While supply_ok is 0, an external low of any length raises neither store_req nor standby nor wr_block.
- R11: A store started by the engine itself (store_active without store_req) pulls the line at once, raises no store_req from the line's own low, and leaves standby at 1 until the line is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sampled level of the shared store/busy wire (1 = released) |
| store_active | input | 1 | Store engine is performing a store |
| write_seen | input | 1 | A write has occurred since the last store |
| supply_ok | input | 1 | Supply is above the store threshold |
| acc_evt | input | 1 | Strobe: an SRAM address or control input changed |
| wr_attempt | input | 1 | Strobe: an SRAM write is being attempted |
| line_pull | output | 1 | Enable for the open-drain pull-down of the wire |
| store_req | output | 1 | Store request to the engine, held until acknowledged |
| wr_block | output | 1 | Suppress SRAM writes |
| standby | output | 1 | SRAM disabled, in standby |

## Verification
The assertions watch, on every cycle, the per-cycle rules: the filter only follows a settled synchronizer, the qualifier only fires after a low sample, the grace window only opens with a good supply and closes right after an access or write strobe, a request is only raised with write_seen set and is held until the engine answers, and standby cannot drop while the filtered line is low. Only the bench scenarios show the durations end to end: that short glitches and short lows are dropped, the exact grace length, the skip path, the recovery count after release, the supply block, and that an engine-started store does not re-trigger itself through the shared wire.

// File: rtl/busy_line_pkg.sv
package busy_line_pkg;

    typedef enum logic [2:0] {
        HS_IDLE  = 3'd0,
        HS_GRACE = 3'd1,
        HS_REQ   = 3'd2,
        HS_RUN   = 3'd3,
        HS_HOLD  = 3'd4,
        HS_RECOV = 3'd5
    } hs_state_e;

    typedef struct packed {
        logic pull;
        logic req;
        logic wr_block;
        logic standby;
    } hs_ctrl_t;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

    function automatic hs_ctrl_t decode_ctrl(input hs_state_e s);
        hs_ctrl_t c;
        c.pull     = (s == HS_REQ) || (s == HS_RUN);
        c.req      = (s == HS_REQ);
        c.wr_block = (s != HS_IDLE);
        c.standby  = (s == HS_REQ) || (s == HS_RUN) ||
                     (s == HS_HOLD) || (s == HS_RECOV);
        return c;
    endfunction

endpackage

// File: rtl/line_sync_filter.sv
module line_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_raw,
    output logic line_high
);
    import busy_line_pkg::*;

    localparam int CW = cnt_width(FILT_LEN);

    logic [SYNC_STAGES-1:0] chain;
    logic [CW-1:0]          agree_cnt;
    logic                   synced;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= line_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign synced = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            line_high <= 1'b1;
            agree_cnt <= '0;
        end else if (synced == line_high) begin
            agree_cnt <= '0;
        end else if (agree_cnt == CW'(FILT_LEN - 1)) begin
            line_high <= synced;
            agree_cnt <= '0;
        end else begin
            agree_cnt <= agree_cnt + 1'b1;
        end
    end

    // R2
    filt_settled_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_high) |-> ($past(synced) == line_high));

endmodule

// File: rtl/assert_qualifier.sv
module assert_qualifier #(
    parameter int ASSERT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic line_high,
    output logic long_low
);
    import busy_line_pkg::*;

    localparam int CW = cnt_width(ASSERT_CYC);

    logic [CW-1:0] low_cnt;
    logic          low_ok;

    assign low_ok   = arm && !line_high;
    assign long_low = (low_cnt == CW'(ASSERT_CYC));

    always_ff @(posedge clk) begin
        if (rst || !low_ok)            low_cnt <= '0;
        else if (!long_low)            low_cnt <= low_cnt + 1'b1;
    end

    // R3
    qual_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(long_low) |-> $past(low_ok));

endmodule

// File: rtl/hs_fsm.sv
module hs_fsm #(
    parameter int DELAY_CYC   = 8,
    parameter int RECOVER_CYC = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    line_high,
    input  logic                    long_low,
    input  logic                    supply_ok,
    input  logic                    store_active,
    input  logic                    write_seen,
    input  logic                    acc_evt,
    input  logic                    wr_attempt,
    output busy_line_pkg::hs_ctrl_t ctrl,
    output logic                    arm
);
    import busy_line_pkg::*;

    localparam int CNT_MAX = (DELAY_CYC > RECOVER_CYC) ? DELAY_CYC : RECOVER_CYC;
    localparam int CW      = cnt_width(CNT_MAX);
    localparam logic [CW-1:0] GRACE_LOAD = CW'(DELAY_CYC - 1);
    localparam logic [CW-1:0] RECOV_LOAD = CW'(RECOVER_CYC - 1);

    hs_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          grace_end;

    assign grace_end = acc_evt || wr_attempt || (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HS_IDLE: begin
                if (store_active) begin
                    state_d = HS_RUN;
                end else if (long_low && supply_ok) begin
                    state_d = HS_GRACE;
                    cnt_d   = GRACE_LOAD;
                end
            end
            HS_GRACE: begin
                if (store_active)    state_d = HS_RUN;
                else if (grace_end)  state_d = write_seen ? HS_REQ : HS_HOLD;
                else                 cnt_d   = cnt_q - 1'b1;
            end
            HS_REQ: begin
                if (store_active) state_d = HS_RUN;
            end
            HS_RUN: begin
                if (!store_active) state_d = HS_HOLD;
            end
            HS_HOLD: begin
                if (store_active) begin
                    state_d = HS_RUN;
                end else if (line_high) begin
                    state_d = HS_RECOV;
                    cnt_d   = RECOV_LOAD;
                end
            end
            HS_RECOV: begin
                if (store_active)      state_d = HS_RUN;
                else if (!line_high)   state_d = HS_HOLD;
                else if (cnt_q == '0)  state_d = HS_IDLE;
                else                   cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign ctrl = decode_ctrl(state_q);
    assign arm  = (state_q == HS_IDLE) && !store_active;

    // R10
    grace_needs_supply_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == HS_GRACE) |-> $past(supply_ok));

    // R5
    access_ends_grace_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_GRACE && acc_evt) |=> (state_q != HS_GRACE));

    // R6
    write_ends_grace_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_GRACE && wr_attempt) |=> (state_q != HS_GRACE));

    // R7
    req_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.req) |-> $past(write_seen));

    // R9
    standby_held_low_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.standby && !line_high && !store_active) |=> ctrl.standby);

endmodule

// File: rtl/busy_line_ctrl.sv
module busy_line_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int ASSERT_CYC  = 4,
    parameter int DELAY_CYC   = 8,
    parameter int RECOVER_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic store_active,
    input  logic write_seen,
    input  logic supply_ok,
    input  logic acc_evt,
    input  logic wr_attempt,
    output logic line_pull,
    output logic store_req,
    output logic wr_block,
    output logic standby
);
    import busy_line_pkg::*;

    logic     line_high;
    logic     long_low;
    logic     arm;
    hs_ctrl_t ctrl;

    line_sync_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_filter (
        .clk      (clk),
        .rst      (rst),
        .line_raw (line_in),
        .line_high(line_high)
    );

    assert_qualifier #(
        .ASSERT_CYC(ASSERT_CYC)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .line_high(line_high),
        .long_low (long_low)
    );

    hs_fsm #(
        .DELAY_CYC  (DELAY_CYC),
        .RECOVER_CYC(RECOVER_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .line_high   (line_high),
        .long_low    (long_low),
        .supply_ok   (supply_ok),
        .store_active(store_active),
        .write_seen  (write_seen),
        .acc_evt     (acc_evt),
        .wr_attempt  (wr_attempt),
        .ctrl        (ctrl),
        .arm         (arm)
    );

    assign line_pull = ctrl.pull || store_active;
    assign store_req = ctrl.req;
    assign wr_block  = ctrl.wr_block;
    assign standby   = ctrl.standby;

    // R8
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (store_req && !store_active) |=> (store_req || store_active));

    // R11
    standby_after_store_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(store_active) |=> standby);

endmodule

// File: tb/busy_line_ctrl_tb.sv
module busy_line_ctrl_tb;

    typedef struct {
        string tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_low = 1'b0;
    logic store_active = 1'b0;
    logic write_seen = 1'b0;
    logic supply_ok = 1'b1;
    logic acc_evt = 1'b0;
    logic wr_attempt = 1'b0;
    logic line_pull, store_req, wr_block, standby;
    logic line_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic req_prev = 1'b0;
    exp_item_t exp_q[$];

    always #5 clk = ~clk;

    assign line_w = !(ext_low || line_pull);

    busy_line_ctrl u_dut (
        .clk(clk), .rst(rst), .line_in(line_w), .store_active(store_active),
        .write_seen(write_seen), .supply_ok(supply_ok), .acc_evt(acc_evt),
        .wr_attempt(wr_attempt), .line_pull(line_pull), .store_req(store_req),
        .wr_block(wr_block), .standby(standby)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input logic act, input logic exp, input string tag);
        check(act === exp, tag, int'(act), int'(exp));
    endtask

    task automatic expect_req(input string tag);
        exp_item_t it;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor: every store_req rising edge must match a queued item
    always @(negedge clk) begin
        if (!rst && store_req && !req_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected store_req", 1, 0);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(write_seen === 1'b1, {"R7 request with write_seen ", it.tag},
                      int'(write_seen), 1);
            end
        end
        req_prev = store_req;
    end

    // store engine model
    initial begin
        forever begin
            wait (store_req === 1'b1);
            repeat (3) @(negedge clk);
            store_active = 1'b1;
            repeat (10) @(negedge clk);
            store_active = 1'b0;
            write_seen = 1'b0;
            @(negedge clk);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    task automatic settle();
        repeat (25) @(negedge clk);
    endtask

    task automatic wait_store_done();
        int n = 0;
        while (!store_active && n < 100) begin @(negedge clk); n++; end
        while (store_active && n < 200) begin @(negedge clk); n++; end
        check(n < 200, "R8 engine store completed", n, 0);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        chk_eq(line_pull, 1'b0, "R1 line_pull in reset");
        chk_eq(store_req, 1'b0, "R1 store_req in reset");
        rst = 1'b0;
        @(negedge clk);
        chk_eq(wr_block, 1'b0, "R1 wr_block after reset");
        chk_eq(standby, 1'b0, "R1 standby after reset");
        settle();

        // R2: 2-cycle glitch
        write_seen = 1'b1;
        ext_low = 1'b1;
        repeat (2) @(negedge clk);
        ext_low = 1'b0;
        repeat (20) @(negedge clk);
        chk_eq(wr_block, 1'b0, "R2 glitch wr_block");
        chk_eq(standby, 1'b0, "R2 glitch standby");

        // R3: 3-cycle low, below qualification
        ext_low = 1'b1;
        repeat (3) @(negedge clk);
        ext_low = 1'b0;
        repeat (20) @(negedge clk);
        chk_eq(wr_block, 1'b0, "R3 short low wr_block");
        chk_eq(standby, 1'b0, "R3 short low standby");

        // R4/R8/R9: full line-initiated store, no activity
        write_seen = 1'b1;
        expect_req("full");
        ext_low = 1'b1;
        repeat (6) @(negedge clk);
        chk_eq(wr_block, 1'b0, "R3 not yet qualified");
        repeat (7) @(negedge clk);
        chk_eq(wr_block, 1'b1, "R4 grace wr_block");
        chk_eq(standby, 1'b0, "R4 grace standby");
        n = 0;
        while (!store_req && n < 40) begin @(negedge clk); n++; end
        check(n == 5, "R4 grace length", n, 5);
        chk_eq(line_pull, 1'b1, "R8 pull while requesting");
        wait (store_active === 1'b1);
        @(negedge clk);
        chk_eq(line_pull, 1'b1, "R8 pull while storing");
        chk_eq(store_req, 1'b0, "R8 request dropped after ack");
        wait_store_done();
        repeat (5) @(negedge clk);
        chk_eq(standby, 1'b1, "R9 standby while line held low");
        ext_low = 1'b0;
        repeat (20) @(negedge clk);
        chk_eq(standby, 1'b0, "R9 standby cleared after release");
        chk_eq(wr_block, 1'b0, "R9 writes re-enabled");
        check(exp_q.size() == 0, "R4 expected request seen", exp_q.size(), 0);
        settle();

        // R7/R9: skipped store, exact recovery
        write_seen = 1'b0;
        ext_low = 1'b1;
        repeat (40) @(negedge clk);
        chk_eq(standby, 1'b1, "R7 skip goes standby");
        chk_eq(store_req, 1'b0, "R7 skip raises no request");
        ext_low = 1'b0;
        repeat (8) @(negedge clk);
        chk_eq(standby, 1'b1, "R9 standby during recovery");
        @(negedge clk);
        chk_eq(standby, 1'b0, "R9 standby ends after recovery");
        settle();

        // R5: access event cuts grace
        write_seen = 1'b1;
        expect_req("access");
        ext_low = 1'b1;
        repeat (12) @(negedge clk);
        acc_evt = 1'b1;
        @(negedge clk);
        acc_evt = 1'b0;
        chk_eq(store_req, 1'b1, "R5 access starts store");
        wait_store_done();
        ext_low = 1'b0;
        settle();
        check(exp_q.size() == 0, "R5 expected request seen", exp_q.size(), 0);

        // R6: write attempt during grace
        write_seen = 1'b1;
        expect_req("write");
        ext_low = 1'b1;
        repeat (12) @(negedge clk);
        wr_attempt = 1'b1;
        #1;
        chk_eq(wr_block, 1'b1, "R6 write blocked");
        @(negedge clk);
        wr_attempt = 1'b0;
        chk_eq(store_req, 1'b1, "R6 write starts store");
        wait_store_done();
        ext_low = 1'b0;
        settle();
        check(exp_q.size() == 0, "R6 expected request seen", exp_q.size(), 0);

        // R10: supply low blocks
        supply_ok = 1'b0;
        write_seen = 1'b1;
        ext_low = 1'b1;
        repeat (30) @(negedge clk);
        chk_eq(standby, 1'b0, "R10 no standby on low supply");
        chk_eq(wr_block, 1'b0, "R10 no write block on low supply");
        ext_low = 1'b0;
        repeat (10) @(negedge clk);
        supply_ok = 1'b1;
        settle();

        // R11: engine-initiated store
        write_seen = 1'b1;
        store_active = 1'b1;
        #1;
        chk_eq(line_pull, 1'b1, "R11 engine store pulls line");
        repeat (10) @(negedge clk);
        store_active = 1'b0;
        write_seen = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq(standby, 1'b1, "R11 standby until line high");
        repeat (20) @(negedge clk);
        chk_eq(standby, 1'b0, "R11 standby cleared");
        chk_eq(store_req, 1'b0, "R11 no self-triggered request");
        settle();
        check(exp_q.size() == 0, "R11 no pending request", exp_q.size(), 0);

        finish_run();
    end

endmodule